// File: doc/BRIEF.md
# Prefetching Memory-Read-Line Controller

This block sits between a local read bus and a PCI master engine. Every local access is compared against one programmable address window. A read that lands in a window set up as prefetchable memory is translated into PCI address space and issued to the engine as a memory-read-line burst. The engine returns one beat per word. The first beat answers the local read. The remaining beats are held in a small prefetch queue, and later reads that continue the same address sequence are answered from that queue without touching the bus.

Each queued word keeps the error code its beat arrived with. An error on a word that nobody reads never reaches the local master. An error on a word that is read comes back with the data, and the queue is emptied. A local write that lands in the window empties the queue, as does any prefetch read that does not continue the queued sequence. A window hit that is not prefetchable becomes a single-word transfer and leaves the queue alone.

Top module: `line_prefetch_ctrl`

## Requirements
- R1: An access hits the window when the local address matches `cfg_win_base` in every bit at or above bit `cfg_win_bits`. A read that misses issues no burst and gives no response.
- R2: The PCI address takes bits at or above `cfg_win_bits` from `cfg_win_map` and the lower bits from the local address.
- R3: A prefetch read issues a burst whose `bx_len` is the smallest of three values: 2^`cfg_line_log2` words, MAX_BURST (8), and the number of words left before the next cache-line boundary of the PCI address. Words are 4 bytes.
- R4: A hit read with `cfg_win_io`=1 or `cfg_win_pf_en`=0 issues a burst with `bx_len`=1, and it leaves the queue contents and position unchanged.
- R5: The first beat of a burst is returned on `lb_rdata`, with `lb_rvalid` high for one cycle, one cycle after that beat.
- R6: A prefetch read whose address equals the queued next address (previous address + 4) is answered from the queue one cycle after the request, and no burst is issued.
- R7: A prefetch read that does not match the queued next address discards the queue and issues a new burst.
- R8: A local write that hits the window empties the queue. A write that misses the window leaves the queue unchanged.
- R9: Error codes are 0 none, 1 target timeout, 2 target abort, 3 retry limit, 4 parity, 5 bus mastering off. A consumed word with a nonzero code is returned with `lb_rerr`=1 and that code on `lb_rcode`, and the queue is emptied. If the first beat is in error, the rest of the burst is not queued.
- R10: A nonzero code on a queued word that is never read produces no `lb_rerr`.
- R11: `bx_req` stays high, with `bx_addr` and `bx_len` stable, until the cycle in which `bx_ack` is sampled high.
- R12: After reset `lb_busy`, `bx_req` and `lb_rvalid` are low. `lb_busy` is high from an accepted burst-issuing read until the last beat, and it stays low while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_base | input | 32 | Window base address |
| cfg_win_bits | input | 5 | Window size as log2 of bytes; the low bits pass through |
| cfg_win_map | input | 32 | Replacement for the upper address bits |
| cfg_win_io | input | 1 | Window is I/O space |
| cfg_win_pf_en | input | 1 | Window may use prefetching line reads |
| cfg_line_log2 | input | 3 | Cache-line size as log2 of words |
| lb_req | input | 1 | Local request strobe, one cycle |
| lb_we | input | 1 | Request is a write |
| lb_addr | input | 32 | Local byte address, word aligned |
| lb_busy | output | 1 | Block cannot accept a request |
| lb_rvalid | output | 1 | Read response valid |
| lb_rdata | output | 32 | Read data |
| lb_rerr | output | 1 | Read response carries an error |
| lb_rcode | output | 3 | Error code of the response |
| bx_req | output | 1 | Burst request to the engine |
| bx_addr | output | 32 | Burst PCI start address |
| bx_len | output | 4 | Burst length in words |
| bx_ack | input | 1 | Engine accepted the burst |
| bx_dvalid | input | 1 | Engine data beat valid |
| bx_data | input | 32 | Engine beat data |
| bx_code | input | 3 | Engine beat error code |

## Verification
The assertions assume three things about the inputs. A local request is raised only while `lb_busy` is low. The engine raises `bx_ack` only while `bx_req` is high and then returns exactly `bx_len` beats. The configuration is held constant while a burst is in flight. The bench's engine model acknowledges only a pending request, sometimes after a delay, and sends exactly the requested number of beats. Every bench task waits for `lb_busy` to fall before it changes the configuration or raises a request.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TIMEOUT  = 3'd1,
        ERR_TABORT   = 3'd2,
        ERR_RETRY    = 3'd3,
        ERR_PARITY   = 3'd4,
        ERR_NOMASTER = 3'd5
    } err_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA
    } ctl_state_e;

    typedef struct packed {
        word_t     data;
        err_code_e code;
    } pf_entry_t;

    function automatic addr_t low_mask(input logic [4:0] bits);
        return (addr_t'(1) << bits) - addr_t'(1);
    endfunction

endpackage

// File: rtl/lpc_win_decode.sv
module lpc_win_decode
    import lpc_pkg::*;
(
    input  addr_t      addr,
    input  addr_t      base,
    input  logic [4:0] bits,
    input  addr_t      map,
    input  logic       is_io,
    input  logic       pf_en,
    output logic       hit,
    output logic       line_rd,
    output addr_t      pci_addr
);
    addr_t mask;

    always_comb begin
        mask     = low_mask(bits);
        hit      = ((addr ^ base) & ~mask) == '0;
        line_rd  = hit && !is_io && pf_en;
        pci_addr = (map & ~mask) | (addr & mask);
    end
endmodule

// File: rtl/lpc_burst_size.sv
module lpc_burst_size
    import lpc_pkg::*;
#(
    parameter int MAX_BURST = 8,
    localparam int LW = $clog2(MAX_BURST + 1)
) (
    input  addr_t         pci_addr,
    input  logic [2:0]    line_log2,
    input  logic          is_line,
    output logic [LW-1:0] len
);
    logic [7:0] line_words;
    logic [7:0] word_off;
    logic [7:0] left;

    always_comb begin
        line_words = 8'd1 << line_log2;
        word_off   = pci_addr[9:2] & (line_words - 8'd1);
        left       = line_words - word_off;
        if (!is_line)
            len = LW'(1);
        else if (left > 8'(MAX_BURST))
            len = LW'(MAX_BURST);
        else
            len = LW'(left);
    end
endmodule

// File: rtl/lpc_pf_fifo.sv
module lpc_pf_fifo
    import lpc_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  pf_entry_t     push_entry,
    input  logic          pop,
    output pf_entry_t     front,
    output logic [CW-1:0] count
);
    pf_entry_t     mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !flush && wr_ptr == PW'(g))
                mem[g] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign front = mem[rd_ptr];
endmodule

// File: rtl/line_prefetch_ctrl.sv
module line_prefetch_ctrl
    import lpc_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int MAX_BURST  = 8,
    localparam int LW = $clog2(MAX_BURST + 1),
    localparam int QW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   cfg_win_base,
    input  logic [4:0]    cfg_win_bits,
    input  logic [31:0]   cfg_win_map,
    input  logic          cfg_win_io,
    input  logic          cfg_win_pf_en,
    input  logic [2:0]    cfg_line_log2,
    input  logic          lb_req,
    input  logic          lb_we,
    input  logic [31:0]   lb_addr,
    output logic          lb_busy,
    output logic          lb_rvalid,
    output logic [31:0]   lb_rdata,
    output logic          lb_rerr,
    output logic [2:0]    lb_rcode,
    output logic          bx_req,
    output logic [31:0]   bx_addr,
    output logic [LW-1:0] bx_len,
    input  logic          bx_ack,
    input  logic          bx_dvalid,
    input  logic [31:0]   bx_data,
    input  logic [2:0]    bx_code
);
    ctl_state_e    state;
    logic          win_hit;
    logic          win_line;
    addr_t         win_pci;
    logic [LW-1:0] size_len;
    logic [QW-1:0] q_count;
    pf_entry_t     q_front;
    logic          q_flush;
    logic          q_push;
    logic          q_pop;
    pf_entry_t     q_in;
    addr_t         head_addr;
    addr_t         addr_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] beat_cnt;
    logic          line_q;
    logic          drop_q;
    logic          rd_acc;
    logic          q_hit;
    logic          first_beat;

    lpc_win_decode u_dec (
        .addr     (lb_addr),
        .base     (cfg_win_base),
        .bits     (cfg_win_bits),
        .map      (cfg_win_map),
        .is_io    (cfg_win_io),
        .pf_en    (cfg_win_pf_en),
        .hit      (win_hit),
        .line_rd  (win_line),
        .pci_addr (win_pci)
    );

    lpc_burst_size #(.MAX_BURST(MAX_BURST)) u_size (
        .pci_addr  (win_pci),
        .line_log2 (cfg_line_log2),
        .is_line   (win_line),
        .len       (size_len)
    );

    lpc_pf_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (q_flush),
        .push       (q_push),
        .push_entry (q_in),
        .pop        (q_pop),
        .front      (q_front),
        .count      (q_count)
    );

    // Request decode in the idle state.
    always_comb begin
        rd_acc     = (state == ST_IDLE) && lb_req && !lb_we && win_hit;
        q_hit      = win_line && (q_count != '0) && (lb_addr == head_addr);
        first_beat = (state == ST_DATA) && bx_dvalid && (beat_cnt == '0);
        q_pop      = rd_acc && q_hit && (q_front.code == ERR_NONE);
        q_flush    = ((state == ST_IDLE) && lb_req && lb_we && win_hit)
                   || (rd_acc && win_line && !q_hit)
                   || (rd_acc && q_hit && (q_front.code != ERR_NONE));
        q_push     = (state == ST_DATA) && bx_dvalid && (beat_cnt != '0)
                   && line_q && !drop_q;
        q_in.data  = bx_data;
        q_in.code  = err_code_e'(bx_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            head_addr <= '0;
            addr_q    <= '0;
            len_q     <= '0;
            beat_cnt  <= '0;
            line_q    <= 1'b0;
            drop_q    <= 1'b0;
            lb_rvalid <= 1'b0;
            lb_rdata  <= '0;
            lb_rerr   <= 1'b0;
            lb_rcode  <= '0;
        end else begin
            lb_rvalid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rd_acc && q_hit) begin
                        lb_rvalid <= 1'b1;
                        lb_rdata  <= q_front.data;
                        lb_rerr   <= q_front.code != ERR_NONE;
                        lb_rcode  <= q_front.code;
                        head_addr <= head_addr + addr_t'(4);
                    end else if (rd_acc) begin
                        addr_q <= win_pci;
                        len_q  <= size_len;
                        line_q <= win_line;
                        if (win_line)
                            head_addr <= lb_addr + addr_t'(4);
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (bx_ack) begin
                        beat_cnt <= '0;
                        drop_q   <= 1'b0;
                        state    <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (bx_dvalid) begin
                        if (first_beat) begin
                            lb_rvalid <= 1'b1;
                            lb_rdata  <= bx_data;
                            lb_rerr   <= bx_code != 3'(ERR_NONE);
                            lb_rcode  <= bx_code;
                            drop_q    <= bx_code != 3'(ERR_NONE);
                        end
                        beat_cnt <= beat_cnt + LW'(1);
                        if (beat_cnt == len_q - LW'(1))
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign lb_busy = state != ST_IDLE;
    assign bx_req  = state == ST_REQ;
    assign bx_addr = addr_q;
    assign bx_len  = len_q;
endmodule

// File: rtl/lpc_ctrl_chk.sv
module lpc_ctrl_chk #(
    parameter int FIFO_DEPTH = 8,
    parameter int MAX_BURST  = 8,
    localparam int LW = $clog2(MAX_BURST + 1),
    localparam int QW = $clog2(FIFO_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          lb_req,
    input logic          lb_we,
    input logic          lb_busy,
    input logic          bx_req,
    input logic          bx_ack,
    input logic [31:0]   bx_addr,
    input logic [LW-1:0] bx_len,
    input logic [QW-1:0] q_count,
    input logic          win_hit
);
    // R11
    bx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bx_req && !bx_ack |=> bx_req && $stable(bx_addr) && $stable(bx_len));

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        bx_req |-> (bx_len >= LW'(1)) && (bx_len <= LW'(MAX_BURST)));

    // R8
    flush_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        lb_req && lb_we && win_hit && !lb_busy |=> q_count == '0);

    // R12
    busy_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        bx_req |-> lb_busy);

    // R12
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        !lb_busy && !lb_req |=> !lb_busy);
endmodule

bind line_prefetch_ctrl lpc_ctrl_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .MAX_BURST  (MAX_BURST)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lb_req  (lb_req),
    .lb_we   (lb_we),
    .lb_busy (lb_busy),
    .bx_req  (bx_req),
    .bx_ack  (bx_ack),
    .bx_addr (bx_addr),
    .bx_len  (bx_len),
    .q_count (q_count),
    .win_hit (win_hit)
);

// File: tb/line_prefetch_ctrl_tb.sv
module line_prefetch_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_win_base = 32'h4000_0000;
    logic [4:0]  cfg_win_bits = 5'd16;
    logic [31:0] cfg_win_map  = 32'h8123_0000;
    logic        cfg_win_io = 1'b0;
    logic        cfg_win_pf_en = 1'b1;
    logic [2:0]  cfg_line_log2 = 3'd3;
    logic        lb_req = 1'b0;
    logic        lb_we = 1'b0;
    logic [31:0] lb_addr = '0;
    logic        lb_busy, lb_rvalid, lb_rerr;
    logic [31:0] lb_rdata;
    logic [2:0]  lb_rcode;
    logic        bx_req;
    logic [31:0] bx_addr;
    logic [3:0]  bx_len;
    logic        bx_ack = 1'b0;
    logic        bx_dvalid = 1'b0;
    logic [31:0] bx_data = '0;
    logic [2:0]  bx_code = '0;

    int checks = 0;
    int failures = 0;
    int bursts = 0;
    int rerr_seen = 0;
    logic [31:0] last_addr = '0;
    int last_len = 0;
    logic [2:0] err_tab [8];
    int ack_wait = 0;
    bit done = 0;

    always #4 clk = ~clk;

    line_prefetch_ctrl u_dut (.*);

    function automatic logic [31:0] beat_val(input logic [31:0] pa);
        return pa ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] to_pci(input logic [31:0] a);
        logic [31:0] m = (32'd1 << cfg_win_bits) - 32'd1;
        return (cfg_win_map & ~m) | (a & m);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Engine model: acknowledges a pending request, then sends len beats.
    int eng_left = 0;
    int eng_idx = 0;
    int eng_wait = 0;
    logic [31:0] eng_pa = '0;
    logic [31:0] seen_addr = '0;
    bit waiting = 0;
    always @(negedge clk) begin
        bx_ack    = 1'b0;
        bx_dvalid = 1'b0;
        bx_code   = '0;
        if (rst) begin
            eng_left = 0; eng_wait = 0; waiting = 0;
        end else if (eng_left > 0) begin
            bx_dvalid = 1'b1;
            bx_data   = beat_val(eng_pa + 32'(eng_idx * 4));
            bx_code   = err_tab[eng_idx];
            eng_idx++;
            eng_left--;
        end else if (bx_req) begin
            if (!waiting) begin
                waiting = 1; seen_addr = bx_addr;
            end else if (bx_addr != seen_addr) begin
                chk(0, "R11", "bx_addr moved while waiting", bx_addr, seen_addr);
            end
            if (eng_wait < ack_wait) begin
                eng_wait++;
            end else begin
                bx_ack = 1'b1;
                eng_wait = 0; waiting = 0;
                eng_pa = bx_addr; eng_left = int'(bx_len); eng_idx = 0;
                last_addr = bx_addr; last_len = int'(bx_len);
                bursts++;
            end
        end
    end

    always @(negedge clk) if (!rst && lb_rvalid && lb_rerr) rerr_seen++;

    task automatic clear_errs();
        for (int i = 0; i < 8; i++) err_tab[i] = '0;
    endtask

    task automatic idle_wait();
        @(negedge clk);
        while (lb_busy) @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] a);
        idle_wait();
        lb_req = 1'b1; lb_we = 1'b1; lb_addr = a;
        @(negedge clk);
        lb_req = 1'b0; lb_we = 1'b0;
    endtask

    // new_burst: 1 expects a burst of exp_len, 0 expects service from queue.
    task automatic do_read(input logic [31:0] a, input bit new_burst, input int exp_len,
                           input logic [2:0] exp_code, input string req);
        int b0;
        bit got = 0;
        logic [31:0] d = '0;
        logic e = 0;
        logic [2:0] c = '0;
        logic [31:0] pa = to_pci(a);
        idle_wait();
        b0 = bursts;
        lb_req = 1'b1; lb_we = 1'b0; lb_addr = a;
        @(negedge clk);
        lb_req = 1'b0;
        for (int i = 0; i < 60 && !got; i++) begin
            if (lb_rvalid) begin
                got = 1; d = lb_rdata; e = lb_rerr; c = lb_rcode;
            end else @(negedge clk);
        end
        idle_wait();
        chk(got, req, "response seen", 32'(got), 1);
        chk(d == beat_val(pa), req, "read data", d, beat_val(pa));
        chk(c == exp_code && e == (exp_code != 0), req, "error code", {28'd0, e, c},
            {28'd0, exp_code != 0, exp_code});
        chk(bursts - b0 == int'(new_burst), req, "burst issued", 32'(bursts - b0),
            32'(new_burst));
        if (new_burst) begin
            chk(last_addr == pa, req, "burst address", last_addr, pa);
            chk(last_len == exp_len, req, "burst length", 32'(last_len), 32'(exp_len));
        end
    endtask

    task automatic t_reset();
        chk(!lb_busy && !bx_req && !lb_rvalid, "R12", "reset outputs",
            {29'd0, lb_busy, bx_req, lb_rvalid}, 0);
    endtask

    task automatic t_line_and_queue();
        do_read(32'h4000_0000, 1, 8, 0, "R3 R5 R2 full line");
        for (int k = 1; k < 8; k++)
            do_read(32'h4000_0000 + 32'(4 * k), 0, 0, 0, "R6 sequential from queue");
        do_read(32'h4000_0020, 1, 8, 0, "R6 queue drained");
    endtask

    task automatic t_boundary();
        do_read(32'h4000_0110, 1, 4, 0, "R3 cut at line boundary");
        cfg_line_log2 = 3'd4;
        do_read(32'h4000_0200, 1, 8, 0, "R3 capped at MAX_BURST");
        do_read(32'h4000_0220, 1, 8, 0, "R3 line 16 mid start");
        cfg_line_log2 = 3'd2;
        do_read(32'h4000_0300, 1, 4, 0, "R3 short line");
        cfg_line_log2 = 3'd3;
    endtask

    task automatic t_nonseq();
        do_read(32'h4000_0400, 1, 8, 0, "R7 setup");
        do_read(32'h4000_040C, 1, 5, 0, "R7 skip issues burst");
        do_read(32'h4000_0410, 0, 0, 0, "R7 new queue sequential");
    endtask

    task automatic t_write_flush();
        do_read(32'h4000_0500, 1, 8, 0, "R8 setup");
        do_write(32'h4000_9000);
        do_read(32'h4000_0504, 1, 7, 0, "R8 write hit flushes");
        do_read(32'h4000_0600, 1, 8, 0, "R8 setup miss");
        do_write(32'h5000_0000);
        do_read(32'h4000_0604, 0, 0, 0, "R8 write miss keeps queue");
    endtask

    task automatic t_err_consumed();
        clear_errs(); err_tab[2] = 3'd4;
        do_read(32'h4000_0700, 1, 8, 0, "R9 setup");
        clear_errs();
        do_read(32'h4000_0704, 0, 0, 0, "R9 clean word");
        do_read(32'h4000_0708, 0, 0, 3'd4, "R9 parity returned");
        do_read(32'h4000_070C, 1, 5, 0, "R9 queue emptied");
        clear_errs(); err_tab[0] = 3'd1;
        do_read(32'h4000_0A00, 1, 8, 3'd1, "R9 first beat timeout");
        clear_errs();
        do_read(32'h4000_0A04, 1, 7, 0, "R9 rest not queued");
    endtask

    task automatic t_err_silent();
        int r0;
        clear_errs(); err_tab[3] = 3'd2; err_tab[5] = 3'd5;
        r0 = rerr_seen;
        do_read(32'h4000_0800, 1, 8, 0, "R10 setup");
        clear_errs();
        do_read(32'h4000_0804, 0, 0, 0, "R10 clean word");
        do_write(32'h4000_0000);
        do_read(32'h4000_0900, 1, 8, 0, "R10 after flush");
        chk(rerr_seen == r0, "R10", "no error from unread words", 32'(rerr_seen), 32'(r0));
    endtask

    task automatic t_nonpf();
        do_read(32'h4000_0C00, 1, 8, 0, "R4 setup");
        cfg_win_pf_en = 1'b0;
        do_read(32'h4000_0B00, 1, 1, 0, "R4 prefetch off single word");
        cfg_win_pf_en = 1'b1; cfg_win_io = 1'b1;
        do_read(32'h4000_0B40, 1, 1, 0, "R4 io single word");
        cfg_win_io = 1'b0;
        do_read(32'h4000_0C04, 0, 0, 0, "R4 queue untouched");
    endtask

    task automatic t_miss();
        int b0;
        bit got = 0;
        idle_wait();
        b0 = bursts;
        lb_req = 1'b1; lb_we = 1'b0; lb_addr = 32'h5000_0040;
        @(negedge clk);
        lb_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (lb_rvalid || lb_busy) got = 1;
            @(negedge clk);
        end
        chk(!got, "R1", "miss gives no response", 32'(got), 0);
        chk(bursts == b0, "R1", "miss issues no burst", 32'(bursts - b0), 0);
    endtask

    task automatic t_slow_ack();
        ack_wait = 3;
        do_read(32'h4000_0D00, 1, 8, 0, "R11 delayed ack");
        ack_wait = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        clear_errs();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_line_and_queue();
        t_boundary();
        t_nonseq();
        t_write_flush();
        t_err_consumed();
        t_err_silent();
        t_nonpf();
        t_miss();
        t_slow_ack();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end
endmodule